// File: doc/BRIEF.md
# Four-Channel Byte-Programmed DMA Register Block

This block holds the programming state of four DMA channels behind an 8-bit register port, and runs a simplified transfer engine for them. Software selects a register with a 4-bit offset. A chip select, a read strobe and a write strobe qualify each access. Each channel has a 16-bit address and a 16-bit count. These are reached through the narrow port by two accesses at the same offset, and one byte pointer shared by all channels steers those accesses. Every channel also has a mode register that sets the direction, single or demand pacing, automatic reload and cascade pass-through.

When an unmasked channel raises its request, the engine grants it. One clock later the engine presents the channel's current address with an acknowledge. It then steps the address up by one and the count down by one. The count is programmed as the transfer length minus one, so the transfer that finds the count at zero is the last one. That transfer raises a terminal-count indication and either reloads the channel from its base values or leaves the count at all-ones and masks the channel. A status register collects the terminal-count events until software reads it.

Top module: `dma4_regif`

## Requirements
- R1: Channel c has its address at offset 2c and its count at offset 2c+1 (offsets 0 to 7). Each 16-bit value takes two accesses at the same offset, low byte first. A single byte pointer, shared by all channels, flips on every read or write at offsets 0 to 7. A write loads the byte into both the base and the current register. A read returns the byte of the current register, one cycle after the strobe.
- R2: A write of any data to offset 11 returns the byte pointer to the low byte.
- R3: All four channels are masked when reset ends, and a masked channel never acknowledges its request. At offset 9, data bits 1:0 pick a channel and bit 2 sets (1) or clears (0) its mask. At offset 12, data bits 3:0 load all four masks, with 1 meaning masked.
- R4: A granted non-cascade channel drives `dack`, `bus_valid` and its current address on `bus_addr` one cycle after the request is sampled. Its address then increments by one and its count decrements by one, both wrapping at 16 bits.
- R5: A count programmed as N-1 gives N transfers, and `bus_tc` is high on the last of them. Without automatic reload, the count then reads 0xFFFF and the channel masks itself.
- R6: With automatic reload, the transfer that ends the count reloads the current address and count from the base values, and the channel stays unmasked.
- R7: At offset 10, data bits 1:0 pick the channel. Bit 2 selects the direction (1 = device to memory), which appears on `bus_to_mem` during that channel's transfers. Bit 3 enables automatic reload, bit 4 selects demand pacing (0 = single) and bit 5 selects cascade.
- R8: A single-paced channel is granted at most once in any two consecutive cycles. A demand-paced channel is granted on every cycle while its request stays high.
- R9: A cascade channel answers its request with `dack` one cycle later. `bus_valid` stays low and the channel's address and count do not change.
- R10: Offset 8 reads the terminal-count flags of channels 0 to 3 in bits 3:0, with bits 7:4 at zero. The read clears the flags, except for a flag set by a transfer in the same cycle.
- R11: At most one channel is granted per cycle, and the lowest-numbered eligible channel wins.
- R12: In any cycle with `cs` and `wr` both high, no channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs | input | 1 | Register port select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read strobe, zero otherwise |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one-hot or zero |
| bus_valid | output | 1 | A memory transfer is presented this cycle |
| bus_addr | output | 16 | Memory address of the presented transfer |
| bus_to_mem | output | 1 | Direction of the presented transfer, 1 = into memory |
| bus_tc | output | 1 | The presented transfer is the last of its count |

## Verification
The transfer engine is driven with four request patterns. A request held on a single-paced channel separates correct pacing from back-to-back grants, and it also checks that the self-mask stops the channel after exactly N transfers. A held request on a demand channel with automatic reload, started near the top of the address space, separates reloading from wrapping and shows the address rolling over from 0xFFFF to 0x0000. Two channels requesting together expose a wrong priority order. A request that arrives during a register write exposes a missing write stall. Readbacks through the byte pointer after each pattern show the final address and count, so the all-ones count and the reloaded count can be told apart.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int DW   = 8;
  localparam int RW   = 2 * DW;
  localparam int NCH  = 4;
  localparam int OFFW = 4;
  localparam int CHW  = $clog2(NCH);

  localparam logic [OFFW-1:0] OFF_STATUS = OFFW'(8);
  localparam logic [OFFW-1:0] OFF_SMASK  = OFFW'(9);
  localparam logic [OFFW-1:0] OFF_MODE   = OFFW'(10);
  localparam logic [OFFW-1:0] OFF_PCLR   = OFFW'(11);
  localparam logic [OFFW-1:0] OFF_AMASK  = OFFW'(12);

  localparam int MB_TOMEM  = 2;
  localparam int MB_AUTO   = 3;
  localparam int MB_DEMAND = 4;
  localparam int MB_CASC   = 5;
  localparam int SMB_SET   = 2;

  typedef struct packed {
    logic cascade;
    logic demand;
    logic autoinit;
    logic to_mem;
  } chmode_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_a_lo,
  input  logic          ld_a_hi,
  input  logic          ld_c_lo,
  input  logic          ld_c_hi,
  input  logic [DW-1:0] wdata,
  input  logic          mode_we,
  input  chmode_t       mode_in,
  input  logic          step,
  output chmode_t       mode_o,
  output logic [RW-1:0] cur_addr,
  output logic [RW-1:0] cur_cnt,
  output logic          at_tc,
  output logic          resting
);
  logic [RW-1:0] base_a_q, base_a_n, base_c_q, base_c_n;
  logic [RW-1:0] cur_a_q, cur_a_n, cur_c_q, cur_c_n;
  chmode_t       mode_q;
  logic          rest_q, rest_n;
  logic          move, ld_any;

  assign move   = step & ~mode_q.cascade;
  assign ld_any = ld_a_lo | ld_a_hi | ld_c_lo | ld_c_hi;

  always_comb begin
    base_a_n = base_a_q;
    base_c_n = base_c_q;
    cur_a_n  = cur_a_q;
    cur_c_n  = cur_c_q;
    if (ld_a_lo) begin base_a_n[DW-1:0]  = wdata; cur_a_n[DW-1:0]  = wdata; end
    if (ld_a_hi) begin base_a_n[RW-1:DW] = wdata; cur_a_n[RW-1:DW] = wdata; end
    if (ld_c_lo) begin base_c_n[DW-1:0]  = wdata; cur_c_n[DW-1:0]  = wdata; end
    if (ld_c_hi) begin base_c_n[RW-1:DW] = wdata; cur_c_n[RW-1:DW] = wdata; end
    if (move) begin
      if ((cur_c_q == '0) && mode_q.autoinit) begin
        cur_a_n = base_a_q;
        cur_c_n = base_c_q;
      end else begin
        cur_a_n = cur_a_q + RW'(1);
        cur_c_n = cur_c_q - RW'(1);
      end
    end
    rest_n = step & ~mode_q.demand & ~mode_q.cascade;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_c_q <= '0;
    end else if (ld_any) begin
      base_a_q <= base_a_n;
      base_c_q <= base_c_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_a_q <= '0;
      cur_c_q <= '0;
    end else if (ld_any | move) begin
      cur_a_q <= cur_a_n;
      cur_c_q <= cur_c_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rest_q <= 1'b0;
    else        rest_q <= rest_n;
  end

  assign mode_o   = mode_q;
  assign cur_addr = cur_a_q;
  assign cur_cnt  = cur_c_q;
  assign at_tc    = (cur_c_q == '0) & ~mode_q.cascade;
  assign resting  = rest_q;
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign gnt[i] = req[i];
    end else begin : g_rest
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end
endmodule

// File: rtl/dma4_regif.sv
module dma4_regif
  import dma4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            rd,
  input  logic            wr,
  input  logic [OFFW-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  dack,
  output logic            bus_valid,
  output logic [RW-1:0]   bus_addr,
  output logic            bus_to_mem,
  output logic            bus_tc
);
  logic rs_q1, rs_q2, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  logic wr_acc, rd_acc, in_chan, wr_mode, rd_stat;
  logic [CHW-1:0] sel_ch;
  chmode_t mode_from_data;

  assign wr_acc  = cs & wr;
  assign rd_acc  = cs & rd;
  assign in_chan = (addr < OFFW'(2 * NCH));
  assign sel_ch  = addr[CHW:1];
  assign wr_mode = wr_acc & (addr == OFF_MODE);
  assign rd_stat = rd_acc & (addr == OFF_STATUS);

  assign mode_from_data.cascade  = wdata[MB_CASC];
  assign mode_from_data.demand   = wdata[MB_DEMAND];
  assign mode_from_data.autoinit = wdata[MB_AUTO];
  assign mode_from_data.to_mem   = wdata[MB_TOMEM];

  logic unused_wbits;
  assign unused_wbits = ^wdata[DW-1:MB_CASC+1];

  logic            ptr_q, ptr_n;
  logic [NCH-1:0]  mask_q, mask_n, stat_q, stat_n;
  logic [NCH-1:0]  elig, grant, ch_last, ch_rest, tc_now, auto_v, casc_v;
  chmode_t         ch_mode [NCH];
  logic [RW-1:0]   ch_addr [NCH];
  logic [RW-1:0]   ch_cnt  [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_acc & in_chan & (sel_ch == CHW'(c));

    dma4_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .ld_a_lo  (hit & ~addr[0] & ~ptr_q),
      .ld_a_hi  (hit & ~addr[0] &  ptr_q),
      .ld_c_lo  (hit &  addr[0] & ~ptr_q),
      .ld_c_hi  (hit &  addr[0] &  ptr_q),
      .wdata    (wdata),
      .mode_we  (wr_mode & (wdata[CHW-1:0] == CHW'(c))),
      .mode_in  (mode_from_data),
      .step     (grant[c]),
      .mode_o   (ch_mode[c]),
      .cur_addr (ch_addr[c]),
      .cur_cnt  (ch_cnt[c]),
      .at_tc    (ch_last[c]),
      .resting  (ch_rest[c])
    );

    assign elig[c]   = dreq[c] & ~mask_q[c] & ~ch_rest[c] & ~wr_acc;
    assign tc_now[c] = grant[c] & ch_last[c];
    assign auto_v[c] = ch_mode[c].autoinit;
    assign casc_v[c] = ch_mode[c].cascade;
  end

  dma4_arb #(.N(NCH)) u_arb (
    .req (elig),
    .gnt (grant)
  );

  logic [RW-1:0] word;
  logic [DW-1:0] rdata_n;
  logic [RW-1:0] baddr_n;
  logic          bvalid_n, btom_n, btc_n;
  logic          mask_en, stat_en;

  always_comb begin
    mask_n = mask_q;
    if (wr_acc && (addr == OFF_SMASK)) mask_n[wdata[CHW-1:0]] = wdata[SMB_SET];
    if (wr_acc && (addr == OFF_AMASK)) mask_n = wdata[NCH-1:0];
    mask_n = mask_n | (tc_now & ~auto_v);

    if (wr_acc && (addr == OFF_PCLR))      ptr_n = 1'b0;
    else if ((wr_acc | rd_acc) && in_chan) ptr_n = ~ptr_q;
    else                                   ptr_n = ptr_q;

    stat_n = (rd_stat ? '0 : stat_q) | tc_now;

    word    = addr[0] ? ch_cnt[sel_ch] : ch_addr[sel_ch];
    rdata_n = '0;
    if (rd_acc) begin
      if (in_chan)      rdata_n = ptr_q ? word[RW-1:DW] : word[DW-1:0];
      else if (rd_stat) rdata_n = DW'(stat_q);
    end

    baddr_n = '0;
    btom_n  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (grant[c] && !casc_v[c]) begin
        baddr_n = baddr_n | ch_addr[c];
        btom_n  = btom_n | ch_mode[c].to_mem;
      end
    end
    bvalid_n = |(grant & ~casc_v);
    btc_n    = |tc_now;
  end

  assign mask_en = wr_acc | (|tc_now);
  assign stat_en = rd_stat | (|tc_now);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mask_q <= '1;
    else if (mask_en) mask_q <= mask_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ptr_q <= 1'b0;
    else            ptr_q <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata      <= '0;
      dack       <= '0;
      bus_valid  <= 1'b0;
      bus_addr   <= '0;
      bus_to_mem <= 1'b0;
      bus_tc     <= 1'b0;
    end else begin
      rdata      <= rdata_n;
      dack       <= grant;
      bus_valid  <= bvalid_n;
      bus_addr   <= baddr_n;
      bus_to_mem <= btom_n;
      bus_tc     <= btc_n;
    end
  end
endmodule

// File: rtl/dma4_sva.sv
module dma4_sva
  import dma4_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cs,
  input logic            rd,
  input logic            wr,
  input logic [OFFW-1:0] addr,
  input logic [NCH-1:0]  dreq,
  input logic [NCH-1:0]  dack,
  input logic            bus_valid,
  input logic            bus_tc,
  input logic [NCH-1:0]  mask,
  input logic            ptr,
  input logic [NCH-1:0]  autoinit
);
  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> ((dack & ~$past(dreq)) == '0));

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> ((dack & $past(mask)) == '0));

  assert_tc_on_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tc |-> bus_valid);

  assert_tc_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tc && ((dack & autoinit) == '0)) |-> ((mask & dack) == dack));

  assert_tc_reload_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tc && ((dack & autoinit) != '0)) |-> ((mask & dack) == '0));

  assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && (addr == OFF_PCLR)) |=> !ptr);

  assert_ptr_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && (addr < OFFW'(2 * NCH))) |=> (ptr != $past(ptr)));

  assert_write_stalls_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr) |=> (dack == '0));
endmodule

bind dma4_regif dma4_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .cs        (cs),
  .rd        (rd),
  .wr        (wr),
  .addr      (addr),
  .dreq      (dreq),
  .dack      (dack),
  .bus_valid (bus_valid),
  .bus_tc    (bus_tc),
  .mask      (mask_q),
  .ptr       (ptr_q),
  .autoinit  (auto_v)
);

// File: tb/dma4_regif_tb_top.sv
`timescale 1ns/1ps
module dma4_regif_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs, rd, wr;
  logic [3:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [3:0]  dreq, dack;
  logic        bus_valid, bus_to_mem, bus_tc;
  logic [15:0] bus_addr;

  always #2.5 clk = ~clk;

  dma4_regif dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .dreq(dreq), .dack(dack),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_to_mem(bus_to_mem),
    .bus_tc(bus_tc)
  );

  int n_chk = 0;
  int n_bad = 0;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ca[4], m_ba[4], m_cc[4], m_bc[4];
  logic        m_tom[4], m_ai[4], m_dm[4], m_cas[4], m_rest[4];
  logic [3:0]  m_mk, m_st;
  logic        m_ptr, m_s1, m_s2;
  logic [3:0]  e_dack;
  logic        e_valid, e_tom, e_tc;
  logic [15:0] e_addr;
  logic [7:0]  e_rdata;

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin
      m_ca[i] = 0; m_ba[i] = 0; m_cc[i] = 0; m_bc[i] = 0;
      m_tom[i] = 0; m_ai[i] = 0; m_dm[i] = 0; m_cas[i] = 0; m_rest[i] = 0;
    end
    m_mk = 4'hF; m_st = 0; m_ptr = 0;
    e_dack = 0; e_valid = 0; e_tom = 0; e_tc = 0; e_addr = 0; e_rdata = 0;
  endtask

  task automatic m_step();
    int g = -1;
    logic wc, rc;
    logic [15:0] v;
    logic [3:0] nst;
    int ch;
    wc = cs && wr;
    rc = cs && rd;
    for (int i = 0; i < 4; i++)
      if (g < 0 && dreq[i] && !m_mk[i] && !m_rest[i] && !wc) g = i;
    e_rdata = 0;
    if (rc) begin
      if (addr < 8) begin
        v = addr[0] ? m_cc[addr >> 1] : m_ca[addr >> 1];
        e_rdata = m_ptr ? v[15:8] : v[7:0];
      end else if (addr == 8) e_rdata = {4'b0, m_st};
    end
    e_dack = 0; e_valid = 0; e_addr = 0; e_tom = 0; e_tc = 0;
    nst = (rc && addr == 8) ? 4'h0 : m_st;
    for (int i = 0; i < 4; i++) m_rest[i] = 0;
    if (g >= 0) begin
      e_dack[g] = 1;
      if (!m_cas[g]) begin
        e_valid = 1; e_addr = m_ca[g]; e_tom = m_tom[g];
        if (!m_dm[g]) m_rest[g] = 1;
        if (m_cc[g] == 0) begin
          e_tc = 1; nst[g] = 1;
          if (m_ai[g]) begin m_ca[g] = m_ba[g]; m_cc[g] = m_bc[g]; end
          else begin m_ca[g] = m_ca[g] + 1; m_cc[g] = 16'hFFFF; m_mk[g] = 1; end
        end else begin
          m_ca[g] = m_ca[g] + 1; m_cc[g] = m_cc[g] - 1;
        end
      end
    end
    m_st = nst;
    if (wc) begin
      if (addr < 8) begin
        ch = addr >> 1;
        if (!addr[0]) begin
          if (m_ptr) begin m_ba[ch][15:8] = wdata; m_ca[ch][15:8] = wdata; end
          else       begin m_ba[ch][7:0]  = wdata; m_ca[ch][7:0]  = wdata; end
        end else begin
          if (m_ptr) begin m_bc[ch][15:8] = wdata; m_cc[ch][15:8] = wdata; end
          else       begin m_bc[ch][7:0]  = wdata; m_cc[ch][7:0]  = wdata; end
        end
      end else if (addr == 9) m_mk[wdata[1:0]] = wdata[2];
      else if (addr == 10) begin
        ch = wdata[1:0];
        m_tom[ch] = wdata[2]; m_ai[ch] = wdata[3]; m_dm[ch] = wdata[4]; m_cas[ch] = wdata[5];
      end else if (addr == 12) m_mk = wdata[3:0];
    end
    if (wc && addr == 11) m_ptr = 0;
    else if ((wc || rc) && addr < 8) m_ptr = ~m_ptr;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_reset();
    end else begin
      if (!m_s2) m_reset(); else m_step();
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  // ---------------- per-cycle comparison and port observation ----------------
  int          obs_ack[4];
  int          obs_tc, obs_valid;
  logic [15:0] obs_last;
  logic        obs_b2b, obs_tom;
  logic [3:0]  prev_dack;

  task automatic clear_obs();
    for (int i = 0; i < 4; i++) obs_ack[i] = 0;
    obs_tc = 0; obs_valid = 0; obs_last = 0; obs_b2b = 0; obs_tom = 0;
  endtask

  initial begin
    clear_obs();
    prev_dack = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (dack !== e_dack || bus_valid !== e_valid || bus_tc !== e_tc ||
          (e_valid && (bus_addr !== e_addr || bus_to_mem !== e_tom)) ||
          rdata !== e_rdata) begin
        n_bad++;
        $display("FAIL R4 cycle compare @%0t: actual dack=%h v=%b a=%h dir=%b tc=%b rd=%h expected dack=%h v=%b a=%h dir=%b tc=%b rd=%h",
                 $time, dack, bus_valid, bus_addr, bus_to_mem, bus_tc, rdata,
                 e_dack, e_valid, e_addr, e_tom, e_tc, e_rdata);
      end
      for (int i = 0; i < 4; i++) begin
        if (dack[i]) obs_ack[i]++;
        if (dack[i] && prev_dack[i]) obs_b2b = 1;
      end
      if (bus_tc) obs_tc++;
      if (bus_valid) begin obs_valid++; obs_last = bus_addr; obs_tom = obs_tom | bus_to_mem; end
      prev_dack = dack;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = o; wdata = d;
    @(negedge clk); cs = 0; wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd_reg(input logic [3:0] o, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = o;
    @(negedge clk); cs = 0; rd = 0; addr = 0;
    d = rdata;
  endtask

  task automatic rd_word(input logic [3:0] o, output logic [15:0] w);
    logic [7:0] lo, hi;
    wr_reg(4'd11, 8'h5A);
    rd_reg(o, lo);
    rd_reg(o, hi);
    w = {hi, lo};
  endtask

  task automatic wr_word(input logic [3:0] o, input logic [15:0] w);
    wr_reg(4'd11, 8'h00);
    wr_reg(o, w[7:0]);
    wr_reg(o, w[15:8]);
  endtask

  task automatic hold_req(input logic [3:0] m, input int n);
    @(negedge clk); dreq = m;
    repeat (n) @(negedge clk);
    dreq = 0;
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    rst_n = 0; cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0; dreq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    rd_reg(4'd8, b);  chk("R10", "status after reset", b, 8'h00);
    rd_word(4'd0, w); chk("R1", "ch0 address after reset", w, 16'h0000);
    clear_obs();
    hold_req(4'hF, 4);
    chk("R3", "acks while all masked", obs_ack[0]+obs_ack[1]+obs_ack[2]+obs_ack[3], 0);

    // channel 1: single, into memory, 5 transfers
    wr_reg(4'd10, 8'h05);
    wr_word(4'd2, 16'h12F0);
    wr_word(4'd3, 16'h0004);
    rd_word(4'd2, w); chk("R1", "ch1 address readback", w, 16'h12F0);
    wr_reg(4'd9, 8'h01);
    clear_obs();
    hold_req(4'h2, 12);
    chk("R5", "ch1 transfer count", obs_ack[1], 5);
    chk("R5", "ch1 terminal count pulses", obs_tc, 1);
    chk("R4", "ch1 last address", obs_last, 16'h12F4);
    chk("R8", "ch1 back-to-back grants", obs_b2b, 0);
    chk("R7", "ch1 direction into memory", obs_tom, 1);
    rd_word(4'd3, w); chk("R5", "ch1 count after end", w, 16'hFFFF);
    rd_word(4'd2, w); chk("R4", "ch1 address after end", w, 16'h12F5);
    rd_reg(4'd8, b);  chk("R10", "status shows ch1", b, 8'h02);
    rd_reg(4'd8, b);  chk("R10", "status cleared by read", b, 8'h00);
    clear_obs();
    hold_req(4'h2, 4);
    chk("R5", "ch1 self-masked", obs_ack[1], 0);

    // channel 2: demand, auto reload, from memory, address wraps
    wr_reg(4'd10, 8'h1A);
    wr_word(4'd4, 16'hFFFE);
    wr_word(4'd5, 16'h0002);
    wr_reg(4'd12, 8'h0B);
    clear_obs();
    hold_req(4'h4, 6);
    chk("R6", "ch2 transfers across reload", obs_ack[2], 6);
    chk("R6", "ch2 terminal count pulses", obs_tc, 2);
    chk("R8", "ch2 demand back-to-back", obs_b2b, 1);
    chk("R4", "ch2 wrapped last address", obs_last, 16'h0000);
    chk("R7", "ch2 direction from memory", obs_tom, 0);
    rd_word(4'd5, w); chk("R6", "ch2 count reloaded", w, 16'h0002);
    rd_word(4'd4, w); chk("R6", "ch2 address reloaded", w, 16'hFFFE);
    rd_reg(4'd8, b);  chk("R10", "status shows ch2", b, 8'h04);

    // channels 0 and 3: demand, priority
    wr_reg(4'd10, 8'h10);
    wr_word(4'd0, 16'h0100);
    wr_word(4'd1, 16'h00FF);
    wr_reg(4'd10, 8'h13);
    wr_word(4'd6, 16'h3000);
    wr_word(4'd7, 16'h00FF);
    wr_reg(4'd12, 8'h00);
    clear_obs();
    hold_req(4'h9, 3);
    chk("R11", "ch0 wins over ch3", obs_ack[0], 3);
    chk("R11", "ch3 starved", obs_ack[3], 0);
    chk("R4", "ch0 third address", obs_last, 16'h0102);

    // write stall
    clear_obs();
    @(negedge clk); dreq = 4'h1; cs = 1; wr = 1; addr = 4'd11; wdata = 8'h00;
    @(negedge clk); cs = 0; wr = 0; addr = 0; dreq = 0;
    @(negedge clk);
    chk("R12", "no grant during register write", obs_ack[0], 0);

    // cascade on channel 3
    rd_word(4'd6, w); chk("R4", "ch3 address before cascade", w, 16'h3000);
    wr_reg(4'd10, 8'h23);
    clear_obs();
    hold_req(4'h8, 3);
    chk("R9", "cascade acks", obs_ack[3], 3);
    chk("R9", "cascade memory cycles", obs_valid, 0);
    rd_word(4'd6, w); chk("R9", "ch3 address untouched", w, 16'h3000);

    // single mask set on channel 0
    wr_reg(4'd9, 8'h04);
    clear_obs();
    hold_req(4'h1, 3);
    chk("R3", "ch0 masked by single write", obs_ack[0], 0);
    rd_word(4'd0, w); chk("R2", "pointer clear gives low then high", w, 16'h0103);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule